// File: doc/BRIEF.md
# Generic Command Packet Engine

This block sits between a register-mapped host port and a byte-wide serial link for command-mode traffic. Software first loads any payload words into a transmit payload queue. It then writes a 24-bit header word. The header goes into a command queue. The engine takes a header from that queue only once enough payload is present, then sends the four header bytes followed by the payload bytes on a valid/ready transmit stream.

On the receive side, response bytes arrive one per cycle with an end marker. They are packed into 32-bit words and placed in a receive payload queue. The host pops that queue through the same data register that it writes for transmit. A status byte reports the empty state of each queue and a read-done flag. The read-done flag shows that a read request went out and its response has fully arrived. ECC, CRC, lane distribution and the physical layer are outside this block. The fourth header byte is sent as zero so that a later stage can insert the ECC there.

Top module: `gcmd_engine`

## Requirements
- R1: After reset, status_o is 8'h2A: receive queue empty (bit 1), transmit payload queue empty (bit 3) and command queue empty (bit 5) are set, read-done (bit 7) is clear, and tx_valid_o is low.
- R2: The header word is laid out as data type in bits 5:0, virtual channel (0..3) in bits 7:6, first parameter byte in bits 15:8 and second parameter byte in bits 23:16. It is sent as four bytes in this order: {vc,dt}, first parameter, second parameter, 8'h00.
- R3: A data type with bit 3 set and bits 2:0 nonzero is a long packet. Its two parameter bytes form a 16-bit word count, low byte first, and that many payload bytes follow the header.
- R4: Every other data type (including 8'h08-style types with bits 2:0 zero) is a 4-byte short packet that consumes no payload. Words already queued stay in the payload queue.
- R5: Payload words are sent least-significant byte first. When the word count ends inside a word, the unused upper bytes of that last word are dropped.
- R6: A long header is not started until the payload queue holds at least word-count bytes (4 per queued word). A word count of zero sends the header alone.
- R7: tx_data_o holds steady while tx_valid_o is high and tx_ready_i is low. The byte stream is unchanged by backpressure.
- R8: Status bit 3 is set exactly when the transmit payload queue is empty, and bit 5 exactly when the command queue is empty. Bit 1 is set exactly when the receive queue is empty.
- R9: Received bytes are packed least-significant byte first into 32-bit words. A word is pushed after its fourth byte, or at the byte flagged rx_last_i, with its unfilled upper bytes zero.
- R10: Read-done (status bit 7) sets when the last response byte arrives after a read request has been sent. A read request is a data type with bit 3 clear and bits 2:0 equal to 3'b100 or 3'b110. The flag clears on the next header write. A response ending with no read request pending leaves it clear.
- R11: pld_re_i when the receive queue is empty is ignored. The queue stays empty and later data is read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_we_i | input | 1 | Header write strobe |
| hdr_wdata_i | input | 24 | Header word |
| pld_we_i | input | 1 | Transmit payload word write strobe |
| pld_wdata_i | input | 32 | Transmit payload word |
| pld_re_i | input | 1 | Pop the receive payload queue |
| pld_rdata_o | output | 32 | Head word of the receive payload queue |
| status_o | output | 8 | Bit 1 rx empty, bit 3 tx payload empty, bit 5 command empty, bit 7 read done |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Link accepts the transmit byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_last_i | input | 1 | Marks the final byte of a response |

## Verification
The bound checker checks on every cycle that the transmit byte holds under backpressure and that a new transmission starts only from a non-empty command queue. It also checks that read-done clears after any header write and rises only on a final response byte, and that the empty flags cannot drop without a matching write. The byte order of headers and payload, the word-count gating, the short-versus-long decode and the receive packing with partial words are shown only by the bench scenarios. In those scenarios a scoreboard compares every byte the link accepts against the expected stream.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;
  localparam int HDR_W = 24;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_PLD} tx_st_e;

  function automatic logic is_long(input logic [5:0] dt);
    return dt[3] && (dt[2:0] != 3'b000);
  endfunction

  function automatic logic is_rdreq(input logic [5:0] dt);
    return !dt[3] && ((dt[2:0] == 3'b100) || (dt[2:0] == 3'b110));
  endfunction
endpackage

// File: rtl/gcmd_fifo.sv
module gcmd_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic push, pop;

  assign push = we_i && (cnt_q != CW'(DEPTH));
  assign pop  = re_i && (cnt_q != '0);
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      if (push && !pop) cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/gcmd_tx.sv
module gcmd_tx
  import gcmd_pkg::*;
#(
  parameter int PLD_CW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HDR_W-1:0]  cmd_i,
  input  logic              cmd_avail_i,
  output logic              cmd_pop_o,
  input  logic [WORD_W-1:0] pld_word_i,
  input  logic [PLD_CW-1:0] pld_count_i,
  output logic              pld_pop_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  output logic              rd_sent_o
);
  tx_st_e st_q;
  logic [HDR_W-1:0] hdr_q;
  logic [1:0] idx_q;
  logic [15:0] bcnt_q;
  logic [31:0] avail_bytes;
  logic start, last_b, hdr_end;
  logic [15:0] wc_q;

  assign avail_bytes = 32'(pld_count_i) << 2;
  assign start = cmd_avail_i &&
                 (!is_long(cmd_i[5:0]) || (avail_bytes >= 32'(cmd_i[23:8])));
  assign wc_q    = hdr_q[23:8];
  assign last_b  = (bcnt_q == wc_q - 16'd1);
  assign hdr_end = (st_q == TX_HDR) && tx_ready_i && (idx_q == 2'd3);

  assign cmd_pop_o  = (st_q == TX_IDLE) && start;
  assign pld_pop_o  = (st_q == TX_PLD) && tx_ready_i && ((idx_q == 2'd3) || last_b);
  assign rd_sent_o  = hdr_end && is_rdreq(hdr_q[5:0]);
  assign tx_valid_o = (st_q != TX_IDLE);

  always_comb begin
    tx_data_o = 8'h00;
    if (st_q == TX_HDR) begin
      case (idx_q)
        2'd0: tx_data_o = hdr_q[7:0];
        2'd1: tx_data_o = hdr_q[15:8];
        2'd2: tx_data_o = hdr_q[23:16];
        default: tx_data_o = 8'h00; // ECC slot, filled downstream
      endcase
    end else if (st_q == TX_PLD) begin
      tx_data_o = pld_word_i[8*idx_q +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      hdr_q  <= '0;
      idx_q  <= '0;
      bcnt_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE: if (start) begin
          hdr_q <= cmd_i;
          idx_q <= '0;
          st_q  <= TX_HDR;
        end
        TX_HDR: if (tx_ready_i) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == 2'd3) begin
            bcnt_q <= '0;
            st_q   <= (is_long(hdr_q[5:0]) && (wc_q != 16'd0)) ? TX_PLD : TX_IDLE;
          end
        end
        TX_PLD: if (tx_ready_i) begin
          bcnt_q <= bcnt_q + 16'd1;
          idx_q  <= last_b ? 2'd0 : idx_q + 1'b1;
          if (last_b) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gcmd_rx.sv
module gcmd_rx
  import gcmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rd_sent_i,
  input  logic              hdr_we_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o,
  output logic              rd_done_o
);
  logic [WORD_W-1:0] acc_q;
  logic [1:0] sel_q;
  logic pend_q, done_q;

  always_comb begin
    word_o = acc_q;
    word_o[8*sel_q +: 8] = rx_data_i;
  end

  assign push_o    = rx_valid_i && (rx_last_i || (sel_q == 2'd3));
  assign rd_done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      sel_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (rx_valid_i) begin
        if (push_o) begin
          acc_q <= '0;
          sel_q <= '0;
        end else begin
          acc_q <= word_o;
          sel_q <= sel_q + 1'b1;
        end
      end
      // header write wins over any completion in the same cycle
      if (hdr_we_i) begin
        pend_q <= 1'b0;
        done_q <= 1'b0;
      end else if (pend_q && rx_valid_i && rx_last_i) begin
        pend_q <= 1'b0;
        done_q <= 1'b1;
      end else if (rd_sent_i) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gcmd_engine.sv
module gcmd_engine
  import gcmd_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int TXP_DEPTH = 16,
  parameter int RXP_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hdr_we_i,
  input  logic [23:0] hdr_wdata_i,
  input  logic        pld_we_i,
  input  logic [31:0] pld_wdata_i,
  input  logic        pld_re_i,
  output logic [31:0] pld_rdata_o,
  output logic [7:0]  status_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i
);
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1);
  localparam int TXP_CW = $clog2(TXP_DEPTH + 1);
  localparam int RXP_CW = $clog2(RXP_DEPTH + 1);

  logic [HDR_W-1:0]  cmd_head;
  logic [CMD_CW-1:0] cmd_cnt;
  logic              cmd_pop;
  logic [WORD_W-1:0] txp_head;
  logic [TXP_CW-1:0] txp_cnt;
  logic              txp_pop;
  logic [RXP_CW-1:0] rxp_cnt;
  logic              rx_push, rd_sent, rd_done;
  logic [WORD_W-1:0] rx_word;

  gcmd_fifo #(.WIDTH(HDR_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk_i, .rst_ni,
    .we_i(hdr_we_i), .wdata_i(hdr_wdata_i),
    .re_i(cmd_pop), .rdata_o(cmd_head), .count_o(cmd_cnt)
  );

  gcmd_fifo #(.WIDTH(WORD_W), .DEPTH(TXP_DEPTH)) u_txp_q (
    .clk_i, .rst_ni,
    .we_i(pld_we_i), .wdata_i(pld_wdata_i),
    .re_i(txp_pop), .rdata_o(txp_head), .count_o(txp_cnt)
  );

  gcmd_fifo #(.WIDTH(WORD_W), .DEPTH(RXP_DEPTH)) u_rxp_q (
    .clk_i, .rst_ni,
    .we_i(rx_push), .wdata_i(rx_word),
    .re_i(pld_re_i), .rdata_o(pld_rdata_o), .count_o(rxp_cnt)
  );

  gcmd_tx #(.PLD_CW(TXP_CW)) u_tx (
    .clk_i, .rst_ni,
    .cmd_i(cmd_head), .cmd_avail_i(cmd_cnt != '0), .cmd_pop_o(cmd_pop),
    .pld_word_i(txp_head), .pld_count_i(txp_cnt), .pld_pop_o(txp_pop),
    .tx_valid_o, .tx_data_o, .tx_ready_i,
    .rd_sent_o(rd_sent)
  );

  gcmd_rx u_rx (
    .clk_i, .rst_ni,
    .rx_valid_i, .rx_data_i, .rx_last_i,
    .rd_sent_i(rd_sent), .hdr_we_i,
    .push_o(rx_push), .word_o(rx_word), .rd_done_o(rd_done)
  );

  always_comb begin
    status_o    = 8'h00;
    status_o[1] = (rxp_cnt == '0);
    status_o[3] = (txp_cnt == '0);
    status_o[5] = (cmd_cnt == '0);
    status_o[7] = rd_done;
  end
endmodule

// File: rtl/gcmd_engine_chk.sv
module gcmd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hdr_we_i,
  input logic       pld_we_i,
  input logic [7:0] status_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i,
  input logic       rx_valid_i,
  input logic       rx_last_i
);
  // R7
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R6
  tx_start_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(!status_o[5]));

  // R10
  rd_done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_we_i |=> !status_o[7]);

  // R10
  rd_done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[7]) |-> $past(rx_valid_i && rx_last_i));

  // R8
  rx_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] && !rx_valid_i |=> status_o[1]);

  // R8
  txp_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] && !pld_we_i |=> status_o[3]);
endmodule

bind gcmd_engine gcmd_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hdr_we_i(hdr_we_i), .pld_we_i(pld_we_i),
  .status_o(status_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
  .tx_ready_i(tx_ready_i), .rx_valid_i(rx_valid_i), .rx_last_i(rx_last_i)
);

// File: tb/tb_gcmd_engine.sv
`timescale 1ns/1ps
module tb_gcmd_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hdr_we_i = 1'b0;
  logic [23:0] hdr_wdata_i = '0;
  logic        pld_we_i = 1'b0;
  logic [31:0] pld_wdata_i = '0;
  logic        pld_re_i = 1'b0;
  logic [31:0] pld_rdata_o;
  logic [7:0]  status_o;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b1;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_last_i = 1'b0;

  gcmd_engine dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit bp_en = 1'b0;
  int bp_cnt = 0;
  string cur_req = "R2";
  logic [7:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      if (exp_q.size() == 0) check(cur_req, {24'h0, tx_data_o}, 32'hFFFF_FFFF);
      else check(cur_req, {24'h0, tx_data_o}, {24'h0, exp_q.pop_front()});
    end
    bp_cnt++;
    tx_ready_i = !(bp_en && (bp_cnt % 3 != 0));
  end

  task automatic hdr_wr(input logic [5:0] dt, input logic [1:0] vc,
                        input logic [7:0] p0, input logic [7:0] p1);
    @(negedge clk_i);
    hdr_we_i = 1'b1;
    hdr_wdata_i = {p1, p0, vc, dt};
    @(negedge clk_i);
    hdr_we_i = 1'b0;
  endtask

  task automatic pld_wr(input logic [31:0] w);
    @(negedge clk_i);
    pld_we_i = 1'b1;
    pld_wdata_i = w;
    @(negedge clk_i);
    pld_we_i = 1'b0;
  endtask

  task automatic exp_hdr(input logic [5:0] dt, input logic [1:0] vc,
                         input logic [7:0] p0, input logic [7:0] p1);
    exp_q.push_back({vc, dt});
    exp_q.push_back(p0);
    exp_q.push_back(p1);
    exp_q.push_back(8'h00);
  endtask

  task automatic long_pkt(input logic [5:0] dt, input logic [1:0] vc,
                          input int n, input logic [7:0] seed);
    logic [31:0] w;
    exp_hdr(dt, vc, n[7:0], n[15:8]);
    for (int i = 0; i < n; i++) exp_q.push_back(seed + 8'(i));
    for (int i = 0; i < n; i += 4) begin
      w = '0;
      for (int j = 0; j < 4; j++)
        if (i + j < n) w[8*j +: 8] = seed + 8'(i + j);
        else w[8*j +: 8] = 8'hEE; // filler, must be dropped
      pld_wr(w);
    end
    hdr_wr(dt, vc, n[7:0], n[15:8]);
  endtask

  task automatic drain;
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk_i);
    check({cur_req, " drain"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic last);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_data_i = b;
    rx_last_i = last;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    rx_last_i = 1'b0;
  endtask

  task automatic rx_pop;
    pld_re_i = 1'b1;
    @(negedge clk_i);
    pld_re_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 status", {24'h0, status_o}, 32'h2A);
    check("R1 tx_valid", {31'h0, tx_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 status after release", {24'h0, status_o}, 32'h2A);

    // R2 short packet header layout, vc=1
    cur_req = "R2";
    exp_hdr(6'h15, 2'd1, 8'hA5, 8'h3C);
    hdr_wr(6'h15, 2'd1, 8'hA5, 8'h3C);
    drain();

    // R3 R5 long packet, partial last word
    cur_req = "R3/R5";
    long_pkt(6'h39, 2'd0, 6, 8'h11);
    drain();
    check("R8 txp empty after long", {31'h0, status_o[3]}, 1);

    // R3 word count exactly one word
    cur_req = "R3";
    long_pkt(6'h29, 2'd3, 4, 8'hA0);
    drain();

    // R4 short packet leaves queued payload untouched
    cur_req = "R4";
    pld_wr(32'hCAFE_F00D);
    check("R8 txp non-empty", {31'h0, status_o[3]}, 0);
    exp_hdr(6'h08, 2'd0, 8'h01, 8'h02);
    hdr_wr(6'h08, 2'd0, 8'h01, 8'h02);
    drain();
    check("R4 payload kept", {31'h0, status_o[3]}, 0);
    exp_hdr(6'h39, 2'd2, 8'd4, 8'd0);
    exp_q.push_back(8'h0D); exp_q.push_back(8'hF0);
    exp_q.push_back(8'hFE); exp_q.push_back(8'hCA);
    hdr_wr(6'h39, 2'd2, 8'd4, 8'd0);
    drain();

    // R6 header waits for enough payload
    cur_req = "R6";
    exp_hdr(6'h29, 2'd0, 8'd5, 8'd0);
    for (int i = 0; i < 5; i++) exp_q.push_back(8'h40 + 8'(i));
    hdr_wr(6'h29, 2'd0, 8'd5, 8'd0);
    repeat (10) @(negedge clk_i);
    check("R6 held no payload", {31'h0, tx_valid_o}, 0);
    check("R8 cmd non-empty", {31'h0, status_o[5]}, 0);
    pld_wr(32'h4342_4140);
    repeat (5) @(negedge clk_i);
    check("R6 held 4 of 5 bytes", {31'h0, tx_valid_o}, 0);
    pld_wr(32'h0000_0044);
    drain();
    check("R8 cmd empty", {31'h0, status_o[5]}, 1);

    // R6 zero word count
    cur_req = "R6 wc0";
    exp_hdr(6'h39, 2'd1, 8'd0, 8'd0);
    hdr_wr(6'h39, 2'd1, 8'd0, 8'd0);
    drain();

    // R7 backpressure
    cur_req = "R7";
    bp_en = 1'b1;
    long_pkt(6'h39, 2'd3, 9, 8'h80);
    drain();
    bp_en = 1'b0;

    // R10 response with no pending read, R9 partial packing
    rx_byte(8'h77, 1'b0);
    rx_byte(8'h88, 1'b1);
    check("R10 no pending read", {31'h0, status_o[7]}, 0);
    check("R8 rx non-empty", {31'h0, status_o[1]}, 0);
    check("R9 partial word", pld_rdata_o, 32'h0000_8877);
    rx_pop();
    check("R8 rx empty", {31'h0, status_o[1]}, 1);

    // R11 pop on empty
    rx_pop();
    rx_pop();
    check("R11 still empty", {31'h0, status_o[1]}, 1);

    // R10 read request then response
    cur_req = "R10";
    exp_hdr(6'h14, 2'd2, 8'h0A, 8'h00);
    hdr_wr(6'h14, 2'd2, 8'h0A, 8'h00);
    drain();
    check("R10 not yet done", {31'h0, status_o[7]}, 0);
    rx_byte(8'hDE, 1'b0);
    rx_byte(8'hAD, 1'b0);
    rx_byte(8'hBE, 1'b0);
    rx_byte(8'hEF, 1'b0);
    rx_byte(8'h01, 1'b1);
    check("R10 done set", {31'h0, status_o[7]}, 1);
    check("R9 word0", pld_rdata_o, 32'hEFBE_ADDE);
    rx_pop();
    check("R11 word after empty pops", pld_rdata_o, 32'h0000_0001);
    rx_pop();
    check("R8 rx drained", {31'h0, status_o[1]}, 1);
    exp_hdr(6'h05, 2'd0, 8'h29, 8'h00);
    hdr_wr(6'h05, 2'd0, 8'h29, 8'h00);
    check("R10 done cleared", {31'h0, status_o[7]}, 0);
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule